// File: doc/BRIEF.md
# ATA Strobe Timing Generator

This block produces the active-low read and write strobes for one parallel ATA channel during PIO and multiword DMA transfers. All timing comes from one 32-bit timing word. The word holds two independent profiles: one for data-port transfers and one for task-file register accesses. Each profile has a setup time, an active (strobe low) time and a recovery (strobe high) time. Every field is encoded as the cycle count minus one. The word is loaded through a single write port. That port can either replace the whole word or update only the timing fields, leaving the four mode-enable flags in the top nibble untouched.

A requester raises `req_valid` for one cycle while the block is idle. `req_write` picks the write strobe over the read strobe, and `req_cmd` picks the register profile over the data profile. The block then steps through setup, active and recovery. It raises `done` for one cycle and returns to idle. It takes the profile from the timing word at the moment it accepts the request and keeps it for that whole transfer.

Top module: `ata_strobe_timer`

## Requirements
- R1: After reset, `cfg_word` reads 0x0d029d5e, `rd_n` and `wr_n` are 1, and `busy` and `done` are 0.
- R2: In a data transfer (`req_cmd`=0), the selected strobe stays low for (bits 8:4 of the timing word)+1 consecutive cycles.
- R3: In a data transfer, the strobe stays high for (bits 3:0)+1 cycles after it rises, before the `done` cycle.
- R4: In a data transfer, (bits 24:22)+1 cycles elapse between acceptance and the strobe falling. The first of these is the cycle right after the accepting clock edge.
- R5: In a register transfer (`req_cmd`=1), setup comes from bits 27:25, active from bits 17:13 and recovery from bits 12:9, each plus one cycle. The data fields have no effect.
- R6: `req_write`=1 pulses only `wr_n`, and `req_write`=0 pulses only `rd_n`. The two strobes are never low together, and neither is low while `busy` is 0.
- R7: `busy` is 1 from the cycle after acceptance through the single `done` cycle that follows recovery. The block is idle in the cycle after `done`.
- R8: A request raised while `busy` is 1 is dropped. No further transfer follows the current one.
- R9: With `cfg_timing_only`=0, a write loads all 32 bits of `cfg_wdata`. With `cfg_timing_only`=1, only bits 27:0 are loaded and bits 31:28 keep their value.
- R10: A timing-word write made while a transfer runs has no effect on that transfer. It applies from the next accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Timing word write strobe |
| cfg_timing_only | input | 1 | When 1, the write keeps bits 31:28 |
| cfg_wdata | input | 32 | Timing word write data |
| cfg_word | output | 32 | Current timing word |
| req_valid | input | 1 | Transfer request, taken only when idle |
| req_write | input | 1 | 1 selects the write strobe, 0 the read strobe |
| req_cmd | input | 1 | 1 selects the register-access profile |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume that reset is held low for at least one clock before the first request. They also assume that `req_valid`, `req_write` and `req_cmd` are steady around each rising edge. The flag-retention property assumes no full write lands in the cycle after a timing-only write. To stay within these assumptions, the bench drives every input on the falling edge and holds reset for several cycles. It separates configuration writes by at least one idle cycle and sends requests only from idle, except where it deliberately tests that a request is dropped while a transfer runs.

// File: rtl/ats_pkg.sv
// Package: shared field layout, phase encoding and profile type for the
// ATA strobe timing generator. Assumes a 32-bit timing word whose fields
// all encode (cycles - 1).
package ats_pkg;

    localparam int WORD_W     = 32;
    localparam int FLAG_LSB   = 28;
    localparam int FLAG_W     = WORD_W - FLAG_LSB;

    localparam int SETUP_W    = 3;
    localparam int ACTIVE_W   = 5;
    localparam int RECOV_W    = 4;

    // data profile field positions
    localparam int D_RECOV_LSB  = 0;
    localparam int D_ACTIVE_LSB = 4;
    localparam int D_SETUP_LSB  = 22;
    // register profile field positions
    localparam int C_RECOV_LSB  = 9;
    localparam int C_ACTIVE_LSB = 13;
    localparam int C_SETUP_LSB  = 25;

    localparam int NUM_PROFILES = 2;
    localparam int PROF_DATA    = 0;
    localparam int PROF_CMD     = 1;

    localparam int CNT_W = (ACTIVE_W > RECOV_W) ?
                           ((ACTIVE_W > SETUP_W) ? ACTIVE_W : SETUP_W) :
                           ((RECOV_W > SETUP_W) ? RECOV_W : SETUP_W);

    localparam logic [WORD_W-1:0] SLOW_PIO_WORD = 32'h0d02_9d5e;

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_SETUP  = 3'd1,
        PH_ACTIVE = 3'd2,
        PH_RECOV  = 3'd3,
        PH_DONE   = 3'd4
    } phase_t;

    typedef struct packed {
        logic [SETUP_W-1:0]  setup;
        logic [ACTIVE_W-1:0] active;
        logic [RECOV_W-1:0]  recov;
    } profile_t;

endpackage

// File: rtl/ats_cfg_reg.sv
// Module: holds the timing word. A full write replaces all bits; a
// timing-only write keeps the mode-enable flags above FLAG_LSB.
// Assumes writes are single-cycle strobes synchronous to clk.
module ats_cfg_reg
    import ats_pkg::*;
#(
    parameter int                 W_BITS     = WORD_W,
    parameter int                 KEEP_LSB   = FLAG_LSB,
    parameter logic [W_BITS-1:0]  RESET_WORD = SLOW_PIO_WORD
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic              timing_only,
    input  logic [W_BITS-1:0] wdata,
    output logic [W_BITS-1:0] word
);

    localparam int KEEP_W = W_BITS - KEEP_LSB;

    logic [W_BITS-1:0] word_q;
    logic [W_BITS-1:0] merged;

    // Purpose: build the value a write would store, per write mode.
    always_comb begin
        merged = wdata;
        if (timing_only) begin
            merged[W_BITS-1:KEEP_LSB] = word_q[W_BITS-1:KEEP_LSB];
        end
    end

    // Purpose: timing word storage with reset to the slowest PIO timing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= RESET_WORD;
        end else if (we) begin
            word_q <= merged;
        end
    end

    assign word = word_q;

    logic [KEEP_W-1:0] unused_keep;
    assign unused_keep = merged[W_BITS-1:KEEP_LSB];

endmodule

// File: rtl/ats_profile_sel.sv
// Module: extracts the data and register profiles from the timing word
// and selects one of them for the requested transfer type.
// Pure combinational; assumes the field layout of ats_pkg.
module ats_profile_sel
    import ats_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    input  logic              use_cmd,
    output profile_t          prof
);

    profile_t prof_arr [NUM_PROFILES];

    // Purpose: one field extractor per profile.
    for (genvar g = 0; g < NUM_PROFILES; g++) begin : g_prof
        localparam int S_LSB = (g == PROF_CMD) ? C_SETUP_LSB  : D_SETUP_LSB;
        localparam int A_LSB = (g == PROF_CMD) ? C_ACTIVE_LSB : D_ACTIVE_LSB;
        localparam int R_LSB = (g == PROF_CMD) ? C_RECOV_LSB  : D_RECOV_LSB;
        assign prof_arr[g].setup  = word[S_LSB +: SETUP_W];
        assign prof_arr[g].active = word[A_LSB +: ACTIVE_W];
        assign prof_arr[g].recov  = word[R_LSB +: RECOV_W];
    end

    // Purpose: choose the profile named by the request type.
    always_comb begin
        prof = use_cmd ? prof_arr[PROF_CMD] : prof_arr[PROF_DATA];
    end

endmodule

// File: rtl/ats_phase_seq.sv
// Module: transfer sequencer. Accepts a request only when idle, latches
// the profile and direction, then counts setup, active and recovery
// (each value+1 cycles) followed by one done cycle. Assumes prof is
// valid in the cycle req_valid is high.
module ats_phase_seq
    import ats_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     req_valid,
    input  logic     req_write,
    input  profile_t prof,
    output phase_t   phase,
    output logic     dir_write
);

    phase_t              phase_q;
    logic [CNT_W-1:0]    cnt_q;
    logic [ACTIVE_W-1:0] act_q;
    logic [RECOV_W-1:0]  rec_q;
    logic                wr_q;
    logic                cnt_zero;

    assign cnt_zero = (cnt_q == '0);

    // Purpose: phase register, down-counter and per-transfer latches.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            act_q   <= '0;
            rec_q   <= '0;
            wr_q    <= 1'b0;
        end else begin
            unique case (phase_q)
                PH_IDLE: begin
                    if (req_valid) begin
                        phase_q <= PH_SETUP;
                        cnt_q   <= CNT_W'(prof.setup);
                        act_q   <= prof.active;
                        rec_q   <= prof.recov;
                        wr_q    <= req_write;
                    end
                end
                PH_SETUP: begin
                    if (cnt_zero) begin
                        phase_q <= PH_ACTIVE;
                        cnt_q   <= CNT_W'(act_q);
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                PH_ACTIVE: begin
                    if (cnt_zero) begin
                        phase_q <= PH_RECOV;
                        cnt_q   <= CNT_W'(rec_q);
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                PH_RECOV: begin
                    if (cnt_zero) begin
                        phase_q <= PH_DONE;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                PH_DONE: begin
                    phase_q <= PH_IDLE;
                end
                default: begin
                    phase_q <= PH_IDLE;
                end
            endcase
        end
    end

    assign phase     = phase_q;
    assign dir_write = wr_q;

endmodule

// File: rtl/ata_strobe_timer.sv
// Module: top of the ATA strobe timing generator for one channel.
// Combines the timing word register, profile selection and the transfer
// sequencer, and decodes the strobes from the registered phase.
// Assumes a single synchronous clock and synchronous active-low reset.
module ata_strobe_timer
    import ats_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_timing_only,
    input  logic [WORD_W-1:0] cfg_wdata,
    output logic [WORD_W-1:0] cfg_word,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_cmd,
    output logic              rd_n,
    output logic              wr_n,
    output logic              busy,
    output logic              done
);

    logic [WORD_W-1:0] word;
    profile_t          prof;
    phase_t            phase;
    logic              dir_write;

    ats_cfg_reg #(
        .W_BITS     (WORD_W),
        .KEEP_LSB   (FLAG_LSB),
        .RESET_WORD (SLOW_PIO_WORD)
    ) u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .we          (cfg_we),
        .timing_only (cfg_timing_only),
        .wdata       (cfg_wdata),
        .word        (word)
    );

    ats_profile_sel u_sel (
        .word    (word),
        .use_cmd (req_cmd),
        .prof    (prof)
    );

    ats_phase_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .prof      (prof),
        .phase     (phase),
        .dir_write (dir_write)
    );

    // Purpose: decode strobes and status from the registered phase.
    always_comb begin
        rd_n = !((phase == PH_ACTIVE) && !dir_write);
        wr_n = !((phase == PH_ACTIVE) &&  dir_write);
        busy = (phase != PH_IDLE);
        done = (phase == PH_DONE);
    end

    assign cfg_word = word;

endmodule

// File: rtl/ats_checker.sv
// Module: protocol checker for ata_strobe_timer, attached by bind.
// Assumes reset is applied before the first request.
module ats_checker
    import ats_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic              cfg_timing_only,
    input logic [WORD_W-1:0] cfg_word,
    input logic              req_valid,
    input logic              rd_n,
    input logic              wr_n,
    input logic              busy,
    input logic              done
);

    AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_n || wr_n)); // R6

    AST_NO_STROBE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (rd_n && wr_n)); // R6

    AST_DONE_IMPLIES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy); // R7

    AST_IDLE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!busy && !done)); // R7

    AST_REQ_ACCEPTED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy) |=> busy); // R7

    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy); // R8

    AST_FLAGS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_timing_only) |=>
            (cfg_word[WORD_W-1:FLAG_LSB] == $past(cfg_word[WORD_W-1:FLAG_LSB]))); // R9

    AST_WORD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(cfg_word)); // R9

endmodule

bind ata_strobe_timer ats_checker u_ats_checker (
    .clk             (clk),
    .rst_n           (rst_n),
    .cfg_we          (cfg_we),
    .cfg_timing_only (cfg_timing_only),
    .cfg_word        (cfg_word),
    .req_valid       (req_valid),
    .rd_n            (rd_n),
    .wr_n            (wr_n),
    .busy            (busy),
    .done            (done)
);

// File: tb/tb_ata_strobe_timer.sv
// Bench: sweeps the setup/active/recovery fields of both profiles and
// measures strobe phase lengths at the ports on falling edges.
module tb_ata_strobe_timer;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 190000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic        cfg_timing_only = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_word;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic        req_cmd = 1'b0;
    logic        rd_n, wr_n, busy, done;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ata_strobe_timer dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_timing_only(cfg_timing_only),
        .cfg_wdata(cfg_wdata), .cfg_word(cfg_word),
        .req_valid(req_valid), .req_write(req_write), .req_cmd(req_cmd),
        .rd_n(rd_n), .wr_n(wr_n), .busy(busy), .done(done)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    function automatic logic [31:0] mk_word(input logic [3:0] flags,
        input int cs, input int ca, input int cr,
        input int ds, input int da, input int dr);
        logic [2:0] cs3 = cs[2:0];
        logic [2:0] ds3 = ds[2:0];
        logic [4:0] ca5 = ca[4:0];
        logic [4:0] da5 = da[4:0];
        logic [3:0] cr4 = cr[3:0];
        logic [3:0] dr4 = dr[3:0];
        return {flags, cs3, ds3, 4'b0000, ca5, cr4, da5, dr4};
    endfunction

    task automatic write_cfg(input logic [31:0] w, input logic keep);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = w; cfg_timing_only = keep;
        @(negedge clk);
        cfg_we = 1'b0; cfg_timing_only = 1'b0;
    endtask

    // Runs one transfer and measures phase lengths at falling edges.
    task automatic run_xfer(input logic wr, input logic cmd,
        input bit mid_wr, input logic [31:0] mid_word,
        output int n_set, output int n_act, output int n_rec,
        output int bad_side, output int idle_after);
        int stage = 0;
        int guard = 0;
        logic sel, oth;
        n_set = 0; n_act = 0; n_rec = 0; bad_side = 0;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_cmd = cmd;
        @(negedge clk);
        req_valid = 1'b0;
        if (mid_wr) begin
            cfg_we = 1'b1; cfg_wdata = mid_word; cfg_timing_only = 1'b0;
        end
        while (!done && guard < 200) begin
            sel = wr ? wr_n : rd_n;
            oth = wr ? rd_n : wr_n;
            if (!oth || !busy) bad_side++;
            if (stage == 0 && sel) n_set++;
            else if (!sel) begin stage = 1; n_act++; end
            else begin stage = 2; n_rec++; end
            guard++;
            @(negedge clk);
            cfg_we = 1'b0;
        end
        @(negedge clk);
        idle_after = (!busy && !done && rd_n && wr_n) ? 1 : 0;
    endtask

    task automatic check_xfer(input logic wr, input logic cmd, input string tset,
        input string tact, input string trec, input int es, input int ea, input int er);
        int s, a, r, bs, ia;
        run_xfer(wr, cmd, 1'b0, 32'h0, s, a, r, bs, ia);
        chk(s == es, tset, s, es);
        chk(a == ea, tact, a, ea);
        chk(r == er, trec, r, er);
        chk(bs == 0, "R6 other strobe low or busy dropped", bs, 0);
        chk(ia == 1, "R7 idle after done", ia, 1);
    endtask

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        summary();
    end

    initial begin
        int s, a, r, bs, ia;
        logic [31:0] w;
        int act_set [6] = '{0, 1, 2, 7, 16, 31};
        repeat (4) @(negedge clk);
        // R1 reset state
        chk(cfg_word == 32'h0d029d5e, "R1 reset word", int'(cfg_word), 32'h0d029d5e);
        chk(rd_n && wr_n, "R1 strobes high", {rd_n, wr_n}, 3);
        chk(!busy && !done, "R1 busy/done low", {busy, done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cfg_word == 32'h0d029d5e && rd_n && wr_n && !busy, "R1 after release",
            int'(cfg_word), 32'h0d029d5e);

        // Default word: data setup 4, active 21, recovery 14; cmd 6, 20, 14
        check_xfer(1'b0, 1'b0, "R4 default setup", "R2 default active", "R3 default recov",
                   5, 22, 15);
        check_xfer(1'b1, 1'b1, "R5 default cmd setup", "R5 default cmd active",
                   "R5 default cmd recov", 7, 21, 15);

        // R2 R3 R4 data sweep, read direction; cmd fields held at other values
        for (int ds = 0; ds < 8; ds++)
            for (int ai = 0; ai < 6; ai++)
                for (int dr = 0; dr < 16; dr++) begin
                    write_cfg(mk_word(4'h2, 7 - ds, 9, 3, ds, act_set[ai], dr), 1'b0);
                    check_xfer(1'b0, 1'b0, "R4 data setup", "R2 data active",
                               "R3 data recov", ds + 1, act_set[ai] + 1, dr + 1);
                end

        // R5 R6 register profile sweep, write direction; data fields differ
        for (int cs = 0; cs < 8; cs++)
            for (int ca = 0; ca < 32; ca += 10)
                for (int cr = 0; cr < 16; cr += 5) begin
                    write_cfg(mk_word(4'h1, cs, ca, cr, 7 - cs, 31 - ca, 15 - cr), 1'b0);
                    check_xfer(1'b1, 1'b1, "R5 cmd setup", "R5 cmd active",
                               "R5 cmd recov", cs + 1, ca + 1, cr + 1);
                end

        // R6 data write and register read directions
        write_cfg(mk_word(4'h0, 2, 4, 6, 1, 3, 5), 1'b0);
        check_xfer(1'b1, 1'b0, "R6 data write setup", "R6 data write active",
                   "R6 data write recov", 2, 4, 6);
        check_xfer(1'b0, 1'b1, "R6 cmd read setup", "R6 cmd read active",
                   "R6 cmd read recov", 3, 5, 7);

        // R9 full write then timing-only write keeps flags
        w = mk_word(4'hA, 1, 1, 1, 1, 1, 1);
        write_cfg(w, 1'b0);
        chk(cfg_word == w, "R9 full write", int'(cfg_word), int'(w));
        write_cfg(mk_word(4'h5, 3, 2, 1, 4, 5, 6), 1'b1);
        chk(cfg_word[31:28] == 4'hA, "R9 flags kept", int'(cfg_word[31:28]), 4'hA);
        chk(cfg_word[27:0] == mk_word(4'h0, 3, 2, 1, 4, 5, 6),
            "R9 timing updated", int'(cfg_word[27:0]),
            int'(mk_word(4'h0, 3, 2, 1, 4, 5, 6)));
        write_cfg(mk_word(4'h5, 3, 2, 1, 4, 5, 6), 1'b0);
        chk(cfg_word[31:28] == 4'h5, "R9 full write flags", int'(cfg_word[31:28]), 4'h5);

        // R10 mid-transfer write applies only to the next transfer
        write_cfg(mk_word(4'h0, 0, 0, 0, 2, 3, 4), 1'b0);
        run_xfer(1'b0, 1'b0, 1'b1, mk_word(4'h0, 0, 0, 0, 6, 12, 9), s, a, r, bs, ia);
        chk(s == 3, "R10 old setup kept", s, 3);
        chk(a == 4, "R10 old active kept", a, 4);
        chk(r == 5, "R10 old recov kept", r, 5);
        check_xfer(1'b0, 1'b0, "R10 new setup", "R10 new active", "R10 new recov",
                   7, 13, 10);

        // R8 request during a transfer is dropped
        write_cfg(mk_word(4'h0, 0, 0, 0, 1, 5, 2), 1'b0);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_cmd = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (3) @(negedge clk);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        begin
            int guard = 0;
            while (!done && guard < 100) begin guard++; @(negedge clk); end
        end
        @(negedge clk);
        chk(!busy, "R8 no second transfer", busy, 0);
        repeat (4) begin
            @(negedge clk);
            chk(!busy && rd_n && wr_n, "R8 stays idle", {busy, rd_n, wr_n}, 3);
        end

        summary();
    end

endmodule